// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a single-port synchronous SRAM whose read and write data phases both trail the command by two active clock edges. Because a write takes its data in the same slot where a read would return data, a host can issue reads and writes on consecutive cycles in any mix without idle bus cycles. Address, control, write data and byte-lane strobes all enter through registers. The storage is a small parameterised array of flip-flops.

A command is issued with the load/advance pin low while all three chip selects are asserted. Two of the selects are active-low and one is active-high. With the pin high, the device steps its on-chip burst counter and repeats the last loaded operation on the next address of a four-beat group. The group runs in linear order or in interleaved order, chosen by a static input.

The shared data bus appears as separate input and output vectors plus an output-enable. There is no valid/ready handshake at the data edge, because every beat has a fixed slot. The only way to apply back-pressure is the active-low clock enable. While it is high, the whole pipeline freezes, including operations already in flight. Output enable works asynchronously and affects only the bus drivers.

Top module: `nobubble_sram`

## Requirements
- R1: A read loaded at active edge k drives the stored word on `dq_out` with `dq_oe` high during the cycle that ends at active edge k+2.
- R2: A write loaded at active edge k takes `dq_in` at active edge k+2 and stores it at the command's address.
- R3: Reads and writes may alternate on consecutive cycles. A read whose data slot directly follows a write slot to the same address returns the newly written lanes.
- R4: `lane_wr_n` is sampled with the write data at edge k+2. Lane i covers bits 9i+8..9i. A lane whose strobe is high (1) keeps its old content.
- R5: While `cke_n` is high, all synchronous inputs are ignored and every register holds, so `dq_out`, in-flight reads and in-flight writes are frozen.
- R6: A load cycle with any chip select deasserted starts no operation. Operations already pending still complete, and the bus is not driven in that command's data slot.
- R7: `dq_oe` is low in every data slot that belongs to a write or to no operation.
- R8: With `burst_ilv`=0, advance beat n (n=1..3) uses low address bits (base+n) mod 4. The upper bits stay fixed, and a fourth advance wraps to the base.
- R9: With `burst_ilv`=1, advance beat n uses low address bits base XOR n, with the upper bits fixed.
- R10: An advance cycle repeats the type of the last loaded operation. An advance that follows a deselecting load starts nothing.
- R11: `oe_n` high forces `dq_oe` low at once, without disturbing the pipeline. When `oe_n` returns low, pending read data reappears.
- R12: After reset, no operation is in flight and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| cke_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read (sampled on load) |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| dq_in | input | LANES*LANE_W | Write data bus |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | LANES*LANE_W | Read data bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with a 4-bit address, so that all sixteen words can be filled and read back directly. Every start address is then run through full bursts in both orders and both operation types, which covers each wrap point of the linear and interleaved counts. The same small depth lets every one of the sixteen lane-strobe patterns be applied, and lets a long pseudo-random stream with random clock-enable stalls and deselects hit the same few addresses often. That stream exercises write-to-read forwarding against a reference array.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // Low two address bits for beat n of a four-beat group
  function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                             input logic [1:0] n,
                                             input logic       ilv);
    return ilv ? (base ^ n) : (base + n);
  endfunction

endpackage

// File: rtl/nbs_burst.sv
module nbs_burst
  import nbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              ld_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              iss_vld,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr
);

  logic              active_q;
  op_e               last_op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    if (!ld_n) begin
      iss_vld  = sel;
      iss_op   = we_n ? OP_RD : OP_WR;
      iss_addr = addr;
    end else begin
      iss_vld  = active_q;
      iss_op   = last_op_q;
      iss_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_nx, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      last_op_q <= OP_RD;
      base_q    <= '0;
      cnt_q     <= '0;
    end else if (ce) begin
      if (!ld_n) begin
        active_q <= sel;
        if (sel) begin
          base_q    <= addr;
          cnt_q     <= '0;
          last_op_q <= we_n ? OP_RD : OP_WR;
        end
      end else if (active_q) begin
        cnt_q <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/nbs_array.sv
module nbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_en,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic same_addr;
  assign same_addr = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wr_slice;

    assign wr_slice = wr_data[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (ce && wr_en && wr_lane_en[g]) mem[wr_addr] <= wr_slice;
    end

    // A lane committing in the same edge is forwarded to the reader
    assign rd_data[g*LANE_W +: LANE_W] =
      (same_addr && wr_lane_en[g]) ? wr_slice : mem[rd_addr];
  end

endmodule

// File: rtl/nbs_pipe.sv
module nbs_pipe
  import nbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              iss_vld,
  input  op_e               iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_vld
);

  logic              s1_vld_q;
  op_e               s1_op_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic              s2_vld_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic              s1_rd;

  assign s1_rd = s1_vld_q && (s1_op_q == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_op_q   <= OP_RD;
      s1_addr_q <= '0;
      s2_vld_q  <= 1'b0;
      s2_addr_q <= '0;
      q_vld     <= 1'b0;
      q_data    <= '0;
    end else if (ce) begin
      s1_vld_q  <= iss_vld;
      s1_op_q   <= iss_op;
      s1_addr_q <= iss_addr;
      s2_vld_q  <= s1_vld_q && (s1_op_q == OP_WR);
      s2_addr_q <= s1_addr_q;
      q_vld     <= s1_rd;
      if (s1_rd) q_data <= rd_data;
    end
  end

  assign rd_addr = s1_addr_q;
  assign wr_en   = s2_vld_q;
  assign wr_addr = s2_addr_q;

endmodule

// File: rtl/nobubble_sram.sv
module nobubble_sram
  import nbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    ld_n,
  input  logic                    we_n,
  input  logic                    burst_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              ce;
  logic              sel;
  logic              iss_vld;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data;
  logic              q_vld;

  assign ce  = !cke_n;
  assign sel = !cs1_n && cs2 && !cs3_n;

  nbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .ld_n     (ld_n),
    .sel      (sel),
    .we_n     (we_n),
    .ilv      (burst_ilv),
    .addr     (addr),
    .iss_vld  (iss_vld),
    .iss_op   (iss_op),
    .iss_addr (iss_addr)
  );

  nbs_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .iss_vld  (iss_vld),
    .iss_op   (iss_op),
    .iss_addr (iss_addr),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .q_data   (dq_out),
    .q_vld    (q_vld)
  );

  nbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .ce         (ce),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_lane_en (~lane_wr_n),
    .wr_data    (dq_in),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  assign dq_oe = q_vld && !oe_n;

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              ld_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);

  logic chosen;
  assign chosen = !cs1_n && cs2 && !cs3_n;

  // R11: output enable high always silences the bus
  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R5: a stalled edge leaves the read data register untouched
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dq_out));

  // R1: a read drives the bus in its slot two active edges later
  p_rd_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && chosen && we_n) ##1 !cke_n |=> (dq_oe || oe_n));

  // R7: the data slot of a write is never driven
  p_wr_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && chosen && !we_n) ##1 !cke_n |=> !dq_oe);

  // R6: the data slot of a deselecting load is never driven
  p_desel_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !chosen) ##1 !cke_n |=> !dq_oe);

endmodule

bind nobubble_sram nbs_checker #(.DATA_W(LANES*LANE_W)) u_nbs_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke_n  (cke_n),
  .cs1_n  (cs1_n),
  .cs2    (cs2),
  .cs3_n  (cs3_n),
  .ld_n   (ld_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .dq_oe  (dq_oe),
  .dq_out (dq_out)
);

// File: tb/tb_nobubble_sram.sv
module tb_nobubble_sram;

  localparam int AW  = 4;
  localparam int LN  = 4;
  localparam int LW  = 9;
  localparam int DW  = LN * LW;
  localparam int DEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          ld_n = 1'b0, we_n = 1'b1, burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] lane_wr_n = '0;
  logic [DW-1:0] dq_in = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #10 clk = ~clk;

  nobubble_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .burst_ilv(burst_ilv),
    .addr(addr), .lane_wr_n(lane_wr_n), .dq_in(dq_in), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int errors = 0;

  // reference storage and slot bookkeeping (slot kind: 0 none, 1 read, 2 write)
  logic [DW-1:0] ref_mem [DEP];
  int            sk  [4];
  logic [AW-1:0] sa  [4];
  logic [LN-1:0] sl  [4];
  string         st  [4];
  int            ecnt = 0;
  int            wcount = 0;
  logic          m_act = 1'b0;
  logic          m_wr = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  string         cur_tag = "R1";
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw,
                                          input logic [LN-1:0] strobes_n);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LN; i++)
      if (!strobes_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  // one clock: called at a negedge, returns at the next negedge
  task automatic cyc(input bit ld, input bit rd, input bit [2:0] en,
                     input logic [AW-1:0] a, input bit stall,
                     input logic [LN-1:0] lanes_n);
    int e = ecnt % 4;
    int ne = (ecnt + 2) % 4;
    bit iss = 1'b0;
    bit iss_wr = 1'b0;
    logic [AW-1:0] ia = '0;
    logic [DW-1:0] wd;
    // output check for the slot ending at the coming active edge
    if (sk[e] == 1)
      chk(dq_oe === 1'b1 && dq_out === ref_mem[sa[e]], st[e], dq_out, ref_mem[sa[e]]);
    else
      chk(dq_oe === 1'b0, "R7", {{(DW-1){1'b0}}, dq_oe}, '0);
    // drive write data for a write slot
    wd = {DW{1'b0}} | (DW'(wcount) * 36'h9E3779B1) ^ {4{9'(wcount * 7 + 3)}};
    dq_in = wd;
    lane_wr_n = (sk[e] == 2) ? sl[e] : '0;
    // command inputs
    cke_n = stall;
    ld_n  = !ld;
    we_n  = rd;
    cs1_n = !en[0];
    cs2   = en[1];
    cs3_n = !en[2];
    addr  = a;
    if (!stall) begin
      if (sk[e] == 2) begin
        ref_mem[sa[e]] = merge(ref_mem[sa[e]], wd, sl[e]);
        wcount++;
      end
      sk[e] = 0;
      if (ld) begin
        m_act = (en == 3'b111);
        if (m_act) begin
          m_base = a; m_cnt = 0; m_wr = !rd;
          iss = 1'b1; iss_wr = !rd; ia = a;
        end
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1;
        iss = 1'b1; iss_wr = m_wr;
        ia = {m_base[AW-1:2],
              burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      end
      if (iss) begin
        sk[ne] = iss_wr ? 2 : 1;
        sa[ne] = ia;
        sl[ne] = lanes_n;
        st[ne] = cur_tag;
      end
      ecnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 3'b000, '0, 1'b0, '0);
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) sk[i] = 0;
    for (int i = 0; i < DEP; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(dq_oe === 1'b0, "R12", {{(DW-1){1'b0}}, dq_oe}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R12", {{(DW-1){1'b0}}, dq_oe}, '0);

    // R2: fill every word back to back, then read every word (R1)
    cur_tag = "R2";
    for (int i = 0; i < DEP; i++) cyc(1'b1, 1'b0, 3'b111, AW'(i), 1'b0, '0);
    cur_tag = "R1";
    for (int i = 0; i < DEP; i++) cyc(1'b1, 1'b1, 3'b111, AW'(i), 1'b0, '0);
    idle(3);

    // R3: alternate write/read each cycle, same and neighbouring addresses
    cur_tag = "R3";
    for (int i = 0; i < DEP; i++) begin
      cyc(1'b1, 1'b0, 3'b111, AW'(i), 1'b0, '0);
      cyc(1'b1, 1'b1, 3'b111, AW'(i), 1'b0, '0);
      cyc(1'b1, 1'b1, 3'b111, AW'(i + 1), 1'b0, '0);
      cyc(1'b1, 1'b0, 3'b111, AW'(i + 3), 1'b0, '0);
    end
    idle(3);

    // R4: every lane-strobe pattern, each followed by a read
    cur_tag = "R4";
    for (int p = 0; p < 16; p++) begin
      cyc(1'b1, 1'b0, 3'b111, AW'(p), 1'b0, LN'(p));
      cyc(1'b1, 1'b1, 3'b111, AW'(p), 1'b0, '0);
    end
    idle(3);

    // R8/R9/R10: bursts from every base, both orders, both types, with wrap
    for (int o = 0; o < 2; o++) begin
      idle(3);
      burst_ilv = o[0];
      cur_tag = o ? "R9" : "R8";
      for (int b = 0; b < DEP; b++) begin
        cyc(1'b1, 1'b0, 3'b111, AW'(b), 1'b0, LN'(b));
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 3'b000, '0, 1'b0, LN'(k));
        cyc(1'b1, 1'b1, 3'b111, AW'(b), 1'b0, '0);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 3'b000, '0, 1'b0, '0);
      end
    end
    idle(3);
    burst_ilv = 1'b0;

    // R6/R10: each select off in turn between live operations, then advances
    cur_tag = "R6";
    for (int s = 0; s < 3; s++) begin
      cyc(1'b1, 1'b0, 3'b111, AW'(s + 5), 1'b0, '0);
      cyc(1'b1, 1'b1, 3'b111, AW'(s + 5), 1'b0, '0);
      cyc(1'b1, 1'b1, 3'b111 & ~(3'b001 << s), AW'(s), 1'b0, '0);
      cur_tag = "R10";
      cyc(1'b0, 1'b1, 3'b111, AW'(s), 1'b0, '0);
      cyc(1'b0, 1'b0, 3'b111, AW'(s), 1'b0, '0);
      cur_tag = "R6";
    end
    idle(3);

    // R11: pending read hidden and restored by output enable
    cyc(1'b1, 1'b1, 3'b111, AW'(9), 1'b0, '0);
    cyc(1'b1, 1'b1, 3'b000, '0, 1'b0, '0);
    oe_n = 1'b1;
    #1;
    chk(dq_oe === 1'b0, "R11", {{(DW-1){1'b0}}, dq_oe}, '0);
    oe_n = 1'b0;
    #1;
    chk(dq_oe === 1'b1 && dq_out === ref_mem[9], "R11", dq_out, ref_mem[9]);
    cur_tag = "R1";
    idle(3);

    // R5: mixed random traffic with random clock-enable stalls
    cur_tag = "R5";
    for (int i = 0; i < 600; i++) begin
      lfsr = step_lfsr(lfsr);
      cyc(lfsr[0] | lfsr[1], lfsr[2], (lfsr[3] & lfsr[4]) ? 3'b110 : 3'b111,
          lfsr[8:5], lfsr[9] & lfsr[10], lfsr[14:11]);
    end
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule